// File: doc/BRIEF.md
# Periodic interrupt rate generator

This block turns a time-base clock into a programmable periodic event stream, a square-wave output and a combined interrupt request. A time-base tick enters a prescaler, whose ratio is set by a three-bit divider select, and yields a divided tick at a nominal 32768 Hz. A counter then divides that tick further, and a four-bit rate code picks the power-of-two interval. The meaning of the two lowest non-zero rate codes depends on the divider select.

Three event sources feed a status byte: the periodic event from this block, and update-ended and alarm pulses from an external calendar core. A source flag sets on its event whatever its enable is. The summary bit and the interrupt line are raised only while some set flag has its enable asserted. A read strobe returns the byte and clears every flag on the following edge.

Top module: `prd_irq_gen`

## Requirements
- R1: With rate code 0 the periodic flag (status bit 6) never sets and the square-wave output stays low.
- R2: Rate codes 3 to 15 give a periodic event every 2^(code-1) divided ticks. After the chain leaves its held state, the first event comes one full interval later.
- R3: Rate codes 1 and 2 give intervals of 2^7 and 2^8 divided ticks when the divider select is 3'b010. With any running divider select other than 3'b010, they give 1 and 2 divided ticks.
- R4: Divider select 3'b010 makes every time-base tick a divided tick. 3'b000 makes one divided tick per PRE_FAST time-base ticks, and 3'b001 makes one per PRE_MID. Selects 3'b011 to 3'b111 hold the chain cleared, and no periodic event occurs while it is held.
- R5: When sqw_en is high, the square-wave output toggles on each periodic event and starts low. It is low while sqw_en is low, while the rate code is 0, and while the chain is held.
- R6: Status bit 4 is the update-ended flag, bit 5 the alarm flag and bit 6 the periodic flag. Each flag sets on its event whether or not it is enabled. Bits 3:0 read 0.
- R7: Status bit 7 and irq both equal (bit4 & uie) | (bit5 & aie) | (bit6 & pie).
- R8: While stat_rd is high, stat shows the current flags, and all flags clear at that clock edge. An event arriving in the same cycle as the read leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_tick | input | 1 | Time-base tick, one clock wide |
| dv_sel | input | 3 | Divider select |
| rate_sel | input | 4 | Periodic rate code |
| sqw_en | input | 1 | Square-wave output enable |
| pie | input | 1 | Periodic interrupt enable |
| aie | input | 1 | Alarm interrupt enable |
| uie | input | 1 | Update-ended interrupt enable |
| upd_evt | input | 1 | Update-ended event pulse |
| alm_evt | input | 1 | Alarm event pulse |
| stat_rd | input | 1 | Status read strobe (clear on read) |
| sqw | output | 1 | Square-wave output |
| irq | output | 1 | Interrupt request, active high |
| stat | output | 8 | Status byte |

## Verification
The bench builds the block with PRE_FAST=4 and PRE_MID=2, with the time-base tick held high. At these values, each prescaled rate code finishes in a few dozen clocks. That makes it practical to measure every rate code on the 32768 Hz select, including the 16384-tick interval of code 15, and to sample several codes on both prescaled selects, all within the cycle budget. Randomised enables, event pulses and reads are checked against a bench model of the flags and the request.

// File: rtl/prd_irq_gen.sv
`timescale 1ns/1ps
module prd_irq_gen #(
  parameter int PRE_FAST = 128,
  parameter int PRE_MID  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_tick,
  input  logic [2:0] dv_sel,
  input  logic [3:0] rate_sel,
  input  logic       sqw_en,
  input  logic       pie,
  input  logic       aie,
  input  logic       uie,
  input  logic       upd_evt,
  input  logic       alm_evt,
  input  logic       stat_rd,
  output logic       sqw,
  output logic       irq,
  output logic [7:0] stat
);
  localparam int CNT_W = 15;
  localparam int PRE_MAX = (PRE_FAST > PRE_MID) ? PRE_FAST : PRE_MID;
  localparam int PRE_W = $clog2(PRE_MAX) + 1;

  logic             halt, slow_base, stage_tick, pe;
  logic [PRE_W-1:0] pre_cnt, pre_lim;
  logic [CNT_W-1:0] div_cnt, cnt_nxt, mask;
  logic [3:0]       tap;
  logic             sqw_q, uf, af, pf;

  assign halt      = dv_sel > 3'd2;
  assign slow_base = dv_sel == 3'd2;
  assign pre_lim   = (dv_sel == 3'd0) ? PRE_W'(PRE_FAST - 1) : PRE_W'(PRE_MID - 1);
  assign stage_tick = tb_tick && !halt && (slow_base || pre_cnt == pre_lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     pre_cnt <= '0;
    else if (halt)                  pre_cnt <= '0;
    else if (tb_tick && !slow_base) pre_cnt <= (pre_cnt == pre_lim) ? '0 : pre_cnt + 1'b1;

  always_comb begin
    case (rate_sel)
      4'd1:    tap = slow_base ? 4'd7 : 4'd0;
      4'd2:    tap = slow_base ? 4'd8 : 4'd1;
      default: tap = rate_sel - 4'd1;
    endcase
  end

  assign cnt_nxt = div_cnt + 1'b1;
  assign mask    = (CNT_W'(1) << tap) - 1'b1;
  assign pe      = stage_tick && (rate_sel != 4'd0) && ((cnt_nxt & mask) == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          div_cnt <= '0;
    else if (halt)       div_cnt <= '0;
    else if (stage_tick) div_cnt <= cnt_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         sqw_q <= 1'b0;
    else if (halt || rate_sel == 4'd0)  sqw_q <= 1'b0;
    else if (pe)                        sqw_q <= ~sqw_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      uf <= 1'b0;
      af <= 1'b0;
      pf <= 1'b0;
    end else begin
      uf <= upd_evt | (uf & ~stat_rd);
      af <= alm_evt | (af & ~stat_rd);
      pf <= pe      | (pf & ~stat_rd);
    end

  assign sqw  = sqw_en & sqw_q;
  assign irq  = (uf & uie) | (af & aie) | (pf & pie);
  assign stat = {irq, pf, af, uf, 4'b0000};
endmodule

// File: rtl/prd_irq_gen_chk.sv
`timescale 1ns/1ps
module prd_irq_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] dv_sel,
  input logic [3:0] rate_sel,
  input logic       sqw_en,
  input logic       pie,
  input logic       aie,
  input logic       uie,
  input logic       upd_evt,
  input logic       alm_evt,
  input logic       stat_rd,
  input logic       sqw,
  input logic       irq,
  input logic [7:0] stat
);
  AST_NO_PF_AT_RATE0: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0 && !stat[6]) |=> !stat[6] || $past(rate_sel) != 4'd0); // R1
  AST_HALT_NO_PF: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_sel > 3'd2 && !stat[6]) |=> !stat[6]); // R4
  AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |-> !sqw); // R5
  AST_UPD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> stat[4]); // R6
  AST_ALM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    alm_evt |=> stat[5]); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat[4] && uie) || (stat[5] && aie) || (stat[6] && pie))); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !upd_evt && !alm_evt && rate_sel == 4'd0) |=> stat[5:4] == 2'b00); // R8
endmodule

bind prd_irq_gen prd_irq_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .dv_sel(dv_sel), .rate_sel(rate_sel), .sqw_en(sqw_en),
  .pie(pie), .aie(aie), .uie(uie), .upd_evt(upd_evt), .alm_evt(alm_evt),
  .stat_rd(stat_rd), .sqw(sqw), .irq(irq), .stat(stat)
);

// File: tb/prd_irq_gen_tb.sv
`timescale 1ns/1ps
module prd_irq_gen_tb_top;
  localparam int PF = 4;
  localparam int PM = 2;

  logic clk = 0, rst_n = 0, tb_tick = 1;
  logic [2:0] dv_sel = 3'd7;
  logic [3:0] rate_sel = 0;
  logic sqw_en = 0, pie = 0, aie = 0, uie = 0, upd_evt = 0, alm_evt = 0, stat_rd = 0;
  logic sqw, irq;
  logic [7:0] stat;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prd_irq_gen #(.PRE_FAST(PF), .PRE_MID(PM)) dut_i (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .dv_sel(dv_sel), .rate_sel(rate_sel),
    .sqw_en(sqw_en), .pie(pie), .aie(aie), .uie(uie), .upd_evt(upd_evt), .alm_evt(alm_evt),
    .stat_rd(stat_rd), .sqw(sqw), .irq(irq), .stat(stat));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_cycles(input logic [2:0] dv, input logic [3:0] code);
    int k, mult;
    if (code == 1)      k = (dv == 3'd2) ? 7 : 0;
    else if (code == 2) k = (dv == 3'd2) ? 8 : 1;
    else                k = code - 1;
    mult = (dv == 3'd2) ? 1 : (dv == 3'd0) ? PF : PM;
    return (1 << k) * mult;
  endfunction

  task automatic clear_flags();
    @(negedge clk);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
  endtask

  task automatic measure(input string req, input logic [2:0] dv, input logic [3:0] code);
    int n = exp_cycles(dv, code);
    int early = 0;
    @(negedge clk);
    dv_sel = 3'd7; rate_sel = code; sqw_en = 1;
    clear_flags();
    dv_sel = dv;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i < n && stat[6]) early++;
    end
    check({req, " no early periodic flag"}, early, 0);
    check({req, " periodic flag at interval"}, stat[6], 1);
    check("R5 square wave high after first event", sqw, 1);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic muf, maf, mirq;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R6 reset status", stat, 0);
    check("R7 reset irq", irq, 0);
    check("R5 reset sqw", sqw, 0);

    for (int c = 1; c <= 15; c++) measure((c <= 2) ? "R3 slow" : "R2 slow", 3'd2, 4'(c));
    for (int c = 1; c <= 6; c++) measure((c <= 2) ? "R3 fast R4" : "R2 fast R4", 3'd0, 4'(c));
    for (int c = 1; c <= 6; c++) measure((c <= 2) ? "R3 mid R4" : "R2 mid R4", 3'd1, 4'(c));

    // R5 toggle back low on second event, gated by sqw_en
    measure("R2 slow code3", 3'd2, 4'd3);
    repeat (4) @(negedge clk);
    check("R5 square toggles low", sqw, 0);
    sqw_en = 0;
    repeat (4) @(negedge clk);
    check("R5 square gated off", sqw, 0);

    // R4 halt holds chain
    @(negedge clk); dv_sel = 3'd6; rate_sel = 4'd3;
    clear_flags();
    repeat (100) @(negedge clk);
    check("R4 halt no periodic flag", stat[6], 0);
    check("R5 halt square low", sqw, 0);

    // R1 code 0
    sqw_en = 1; dv_sel = 3'd2; rate_sel = 4'd0;
    clear_flags();
    repeat (300) @(negedge clk);
    check("R1 code0 no periodic flag", stat[6], 0);
    check("R1 code0 square low", sqw, 0);

    // R6 R7 periodic flag without and with enable
    rate_sel = 4'd3; pie = 0;
    clear_flags();
    repeat (5) @(negedge clk);
    check("R6 periodic flag sets while disabled", stat[6], 1);
    check("R7 no irq when disabled", irq, 0);
    pie = 1;
    #1;
    check("R7 irq with pie", irq, 1);
    check("R7 summary bit", stat[7], 1);
    rate_sel = 4'd0; pie = 0;
    clear_flags();

    // R8 event coincident with read retained
    @(negedge clk); upd_evt = 1;
    @(negedge clk); upd_evt = 0; alm_evt = 1; stat_rd = 1;
    #1;
    check("R8 read shows flag", stat[4], 1);
    @(negedge clk); alm_evt = 0; stat_rd = 0;
    check("R8 read cleared update flag", stat[4], 0);
    check("R8 coincident alarm kept", stat[5], 1);
    clear_flags();

    // Random flags/enables/reads, R6 R7 R8
    muf = 0; maf = 0;
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      uie = 1'($urandom); aie = 1'($urandom);
      upd_evt = ($urandom % 6) == 0;
      alm_evt = ($urandom % 6) == 0;
      stat_rd = ($urandom % 4) == 0;
      #1;
      mirq = (muf & uie) | (maf & aie);
      check("R6 R7 random status", stat, {mirq, 1'b0, maf, muf, 4'b0000});
      check("R7 random irq", irq, mirq);
      muf = upd_evt | (muf & ~stat_rd);
      maf = alm_evt | (maf & ~stat_rd);
    end
    @(negedge clk); upd_evt = 0; alm_evt = 0; stat_rd = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule